// File: doc/BRIEF.md
# Two-Stage Converter Clock Divider

This block derives two converter clocks from one fast oscillator clock. The first stage makes the high-rate clock. It divides the oscillator by an even ratio of 2·(N+1), where N is an 8-bit value, and keeps a 50% duty cycle for every N. The second stage makes the low-rate clock. It divides the high-rate clock by 2^K, where K is a 2-bit value. Each output has its own polarity-invert control.

Software writes N into a shadow register. The running divider takes the new value only when a full high-rate period has ended, so no runt pulse reaches the converters. The design runs entirely in the oscillator domain. The second stage advances on the oscillator edge that raises the high-rate clock, so no logic is clocked by a divided clock.

The first stage is a two-state machine. In PH_LOW the high-rate clock is low. On terminal count, PH_LOW moves to PH_HIGH; this transition is the "rise" and advances the post-divider. In PH_HIGH the clock is high. On terminal count, PH_HIGH moves back to PH_LOW; this transition is the "fall" and loads the shadowed N. In every other cycle a state holds and its counter increments.

Top module: `conv_clk_divider`

## Requirements
- R1: A clock edge with `rst_n` low forces both `clk_hi` and `clk_lo` to 0 on the following cycle, whatever `inv_hi` and `inv_lo` are. After reset, the active N is 4 (high-rate period of 10 oscillator cycles) and the active K is 0.
- R2: `clk_hi` has a period of 2·(N+1) oscillator cycles. It is high for exactly N+1 of them and low for N+1.
- R3: A write (`ratio_wr` high at an edge) changes only the shadow N. The active N takes the shadow value at the fall of `clk_hi`. A half-period that is under way keeps the old length, and so does any half-period before that fall. Every half-period after the fall lasts new N+1 cycles.
- R4: The limit values of N behave like any other value: N=0 gives a period of 2 cycles (1 high, 1 low), and N=255 gives a period of 512 cycles (256 high, 256 low).
- R5: For K of 1, 2 or 3, `clk_lo` has a period of 2^K times the `clk_hi` period and a 50% duty cycle. Its edges fall only on oscillator edges that raise `clk_hi`.
- R6: With active K=0, `clk_lo` equals `clk_hi` on every cycle.
- R7: A 3-bit post counter advances on each rise of `clk_hi` and is cleared by reset. `post_sel` is copied into the active K only when this counter wraps from 7 to 0, which happens on every 8th rise after reset. On that rise the counter reads 0, so `clk_lo` is low.
- R8: Each output is XORed with a registered copy of its own invert input, which lags the input by one cycle. `inv_hi` affects only `clk_hi`, and `inv_lo` affects only `clk_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Fast oscillator clock; all registers use its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_wr | input | 1 | Write strobe for the shadow divide value N |
| ratio_wdata | input | 8 | Value of N to be shadowed |
| post_sel | input | 2 | Post-divider exponent K, sampled at counter wrap |
| inv_hi | input | 1 | Invert the high-rate output |
| inv_lo | input | 1 | Invert the low-rate output |
| clk_hi | output | 1 | High-rate converter clock |
| clk_lo | output | 1 | Low-rate converter clock |

## Verification
Two situations are hard to reach from the ports. The first is a write to N that arrives partway through a high-rate period. The stimulus watches `clk_hi` for a fall or a rise and writes on the very next cycle. It then measures run lengths, expecting the remainder of the current period at the old length and later halves at the new one. This is done once with the write in the low half and once in the high half. The second is the K handover at the hidden wrap of the post counter. The bench holds `post_sel` at 1 through reset and counts rises of `clk_hi`. It expects `clk_lo` to follow `clk_hi` exactly until the 8th rise, and then to show the divided waveform. It then moves K again and checks that the change waits for the next wrap.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    localparam int unsigned DEF_RATIO_W = 8;
    localparam int unsigned DEF_SEL_W   = 2;
    localparam int unsigned DEF_RATIO   = 4;
endpackage

// File: rtl/even_div_stage.sv
module even_div_stage
    import cdiv_pkg::*;
#(
    parameter int unsigned RATIO_W   = DEF_RATIO_W,
    parameter int unsigned RATIO_RST = DEF_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_data,
    output logic               hi_raw,
    output logic               rise_next,
    output logic [RATIO_W-1:0] act_ratio
);
    localparam logic [RATIO_W-1:0] RST_VAL = RATIO_W'(RATIO_RST);
    localparam logic [RATIO_W-1:0] ONE     = RATIO_W'(1);

    phase_e             phase_q, phase_d;
    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] shadow_q;
    logic [RATIO_W-1:0] act_q;
    logic               tc;

    assign tc = (cnt_q == act_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_LOW;
        else        phase_q <= phase_d;
    end

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOW:  if (tc) phase_d = PH_HIGH;
            PH_HIGH: if (tc) phase_d = PH_LOW;
            default: phase_d = PH_LOW;
        endcase
    end

    // half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt_q <= '0;
        else if (tc) cnt_q <= '0;
        else         cnt_q <= cnt_q + ONE;
    end

    // shadow register and its transfer at the fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= RST_VAL;
            act_q    <= RST_VAL;
        end else begin
            if (wr_en) shadow_q <= wr_data;
            if (phase_q == PH_HIGH && tc) act_q <= shadow_q;
        end
    end

    // outputs
    always_comb begin
        hi_raw    = (phase_q == PH_HIGH);
        rise_next = (phase_q == PH_LOW) && tc;
        act_ratio = act_q;
    end
endmodule

// File: rtl/pow2_post_stage.sv
module pow2_post_stage
    import cdiv_pkg::*;
#(
    parameter int unsigned SEL_W = DEF_SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    input  logic                        hi_raw,
    input  logic [SEL_W-1:0]            sel_in,
    output logic                        lo_raw,
    output logic [SEL_W-1:0]            act_sel,
    output logic [(1<<SEL_W)-2:0]       cnt
);
    localparam int unsigned TAPS  = 1 << SEL_W;
    localparam int unsigned CNT_W = TAPS - 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [TAPS-1:0]  taps;
    logic             wrap;

    assign wrap = step && (&cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else begin
            if (step) cnt_q <= cnt_q + ONE;
            if (wrap) sel_q <= sel_in;
        end
    end

    assign taps[0] = hi_raw;
    for (genvar i = 1; i < TAPS; i++) begin : g_tap
        assign taps[i] = cnt_q[i-1];
    end

    assign lo_raw  = taps[sel_q];
    assign act_sel = sel_q;
    assign cnt     = cnt_q;
endmodule

// File: rtl/polarity_cell.sv
module polarity_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic inv_in,
    output logic out
);
    logic inv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= 1'b0;
        else        inv_q <= inv_in;
    end

    assign out = raw ^ inv_q;
endmodule

// File: rtl/conv_clk_divider.sv
module conv_clk_divider
    import cdiv_pkg::*;
#(
    parameter int unsigned RATIO_W   = DEF_RATIO_W,
    parameter int unsigned RATIO_RST = DEF_RATIO,
    parameter int unsigned SEL_W     = DEF_SEL_W
) (
    input  logic               clk_osc,
    input  logic               rst_n,
    input  logic               ratio_wr,
    input  logic [RATIO_W-1:0] ratio_wdata,
    input  logic [SEL_W-1:0]   post_sel,
    input  logic               inv_hi,
    input  logic               inv_lo,
    output logic               clk_hi,
    output logic               clk_lo
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1;
    localparam int unsigned N_OUT = 2;

    logic               hi_raw;
    logic               lo_raw;
    logic               rise_next;
    logic [RATIO_W-1:0] act_n;
    logic [SEL_W-1:0]   act_k;
    logic [CNT_W-1:0]   post_cnt;
    logic [N_OUT-1:0]   raw_vec, inv_vec, out_vec;

    even_div_stage #(
        .RATIO_W  (RATIO_W),
        .RATIO_RST(RATIO_RST)
    ) u_even (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .wr_en    (ratio_wr),
        .wr_data  (ratio_wdata),
        .hi_raw   (hi_raw),
        .rise_next(rise_next),
        .act_ratio(act_n)
    );

    pow2_post_stage #(
        .SEL_W(SEL_W)
    ) u_post (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .step   (rise_next),
        .hi_raw (hi_raw),
        .sel_in (post_sel),
        .lo_raw (lo_raw),
        .act_sel(act_k),
        .cnt    (post_cnt)
    );

    assign raw_vec = {lo_raw, hi_raw};
    assign inv_vec = {inv_lo, inv_hi};

    for (genvar g = 0; g < N_OUT; g++) begin : g_pol
        polarity_cell u_pol (
            .clk   (clk_osc),
            .rst_n (rst_n),
            .raw   (raw_vec[g]),
            .inv_in(inv_vec[g]),
            .out   (out_vec[g])
        );
    end

    assign clk_hi = out_vec[0];
    assign clk_lo = out_vec[1];
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
    parameter int unsigned RATIO_W = 8,
    parameter int unsigned SEL_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      inv_hi,
    input logic                      clk_hi,
    input logic                      clk_lo,
    input logic                      hi_raw,
    input logic                      lo_raw,
    input logic [RATIO_W-1:0]        act_n,
    input logic [SEL_W-1:0]          act_k,
    input logic [(1<<SEL_W)-2:0]     post_cnt
);
    logic               armed;
    logic               hi_prev;
    logic [RATIO_W:0]   run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            hi_prev <= 1'b0;
            run_len <= '0;
        end else begin
            armed   <= 1'b1;
            hi_prev <= hi_raw;
            run_len <= (hi_raw != hi_prev) ? (RATIO_W+1)'(1) : run_len + (RATIO_W+1)'(1);
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (clk_hi == 1'b0 && clk_lo == 1'b0));

    assert_half_len_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (hi_raw != $past(hi_raw)) |-> (run_len == {1'b0, $past(act_n)} + (RATIO_W+1)'(1)));

    assert_shadow_load_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (act_n != $past(act_n)) |-> $fell(hi_raw));

    assert_post_edge_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (act_k != '0 && act_k == $past(act_k) && lo_raw != $past(lo_raw)) |-> $rose(hi_raw));

    assert_sel_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (act_k != $past(act_k)) |-> ($rose(hi_raw) && post_cnt == '0));

    assert_invert_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        clk_hi == (hi_raw ^ $past(inv_hi)));
endmodule

bind conv_clk_divider cdiv_checker #(
    .RATIO_W(RATIO_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .inv_hi  (inv_hi),
    .clk_hi  (clk_hi),
    .clk_lo  (clk_lo),
    .hi_raw  (hi_raw),
    .lo_raw  (lo_raw),
    .act_n   (act_n),
    .act_k   (act_k),
    .post_cnt(post_cnt)
);

// File: tb/sim_conv_clk_divider.sv
`timescale 1ns/1ps
module sim_conv_clk_divider;
    logic       clk_osc = 1'b0;
    logic       rst_n = 1'b0;
    logic       ratio_wr = 1'b0;
    logic [7:0] ratio_wdata = 8'd0;
    logic [1:0] post_sel = 2'd0;
    logic       inv_hi = 1'b0;
    logic       inv_lo = 1'b0;
    logic       clk_hi, clk_lo;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk_osc = ~clk_osc;

    conv_clk_divider u0 (
        .clk_osc    (clk_osc),
        .rst_n      (rst_n),
        .ratio_wr   (ratio_wr),
        .ratio_wdata(ratio_wdata),
        .post_sel   (post_sel),
        .inv_hi     (inv_hi),
        .inv_lo     (inv_lo),
        .clk_hi     (clk_hi),
        .clk_lo     (clk_lo)
    );

    // {N, K}
    localparam logic [9:0] VECS [0:5] = '{
        {8'd4,   2'd0},
        {8'd0,   2'd1},
        {8'd1,   2'd2},
        {8'd7,   2'd3},
        {8'd2,   2'd0},
        {8'd255, 2'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input bit lo);
        return lo ? clk_lo : clk_hi;
    endfunction

    task automatic wait_edge(input bit lo, input bit rising);
        logic prev;
        prev = pick(lo);
        while (1) begin
            @(negedge clk_osc);
            if (rising ? (!prev && pick(lo)) : (prev && !pick(lo))) break;
            prev = pick(lo);
        end
    endtask

    task automatic run_len(input bit lo, output int n);
        logic v;
        v = pick(lo);
        n = 1;
        while (1) begin
            @(negedge clk_osc);
            ratio_wr = 1'b0;
            if (pick(lo) != v) break;
            n++;
        end
    endtask

    task automatic period_of(input bit lo, output int per, output int high);
        int a, b;
        wait_edge(lo, 1'b1);
        run_len(lo, a);
        run_len(lo, b);
        per  = a + b;
        high = a;
    endtask

    task automatic wait_rises(input int n);
        for (int i = 0; i < n; i++) wait_edge(1'b0, 1'b1);
    endtask

    task automatic do_reset(input logic [1:0] k);
        @(negedge clk_osc);
        rst_n = 1'b0; ratio_wr = 1'b0; post_sel = k;
        inv_hi = 1'b1; inv_lo = 1'b1;
        repeat (2) @(negedge clk_osc);
        chk("R1 clk_hi in reset", int'(clk_hi), 0);
        chk("R1 clk_lo in reset", int'(clk_lo), 0);
        inv_hi = 1'b0; inv_lo = 1'b0;
        @(negedge clk_osc);
        rst_n = 1'b1;
    endtask

    task automatic write_n(input logic [7:0] n);
        @(negedge clk_osc);
        ratio_wr = 1'b1; ratio_wdata = n;
        @(negedge clk_osc);
        ratio_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk_osc);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int p, h, a, b, c, d, mis, tog;
        string req;

        // R1: default ratio after reset
        do_reset(2'd0);
        period_of(1'b0, p, h);
        chk("R1 default period", p, 10);
        chk("R1 default high time", h, 5);

        // table: R2, R4, R5, R6
        for (int i = 0; i < 6; i++) begin
            int n, k, hp;
            n  = int'(VECS[i][9:2]);
            k  = int'(VECS[i][1:0]);
            hp = 2 * (n + 1);
            req = (n == 0 || n == 255) ? "R4" : "R2";
            do_reset(VECS[i][1:0]);
            write_n(VECS[i][9:2]);
            wait_rises(12);
            period_of(1'b0, p, h);
            chk({req, " hi period"}, p, hp);
            chk({req, " hi high time"}, h, n + 1);
            period_of(1'b1, p, h);
            chk("R5 lo period", p, hp << k);
            chk("R5 lo high time", h, (hp << k) / 2);
            if (k == 0) begin
                mis = 0;
                for (int j = 0; j < 40; j++) begin
                    @(negedge clk_osc);
                    if (clk_lo != clk_hi) mis++;
                end
                chk("R6 lo equals hi mismatches", mis, 0);
            end
        end

        // R3: write during low half (4 -> 9)
        do_reset(2'd0);
        wait_edge(1'b0, 1'b0);
        ratio_wr = 1'b1; ratio_wdata = 8'd9;
        run_len(1'b0, a);
        run_len(1'b0, b);
        run_len(1'b0, c);
        run_len(1'b0, d);
        chk("R3 low half in progress", a, 5);
        chk("R3 high half before fall", b, 5);
        chk("R3 low half after fall", c, 10);
        chk("R3 high half after fall", d, 10);

        // R3: write during high half (9 -> 2)
        wait_edge(1'b0, 1'b1);
        ratio_wr = 1'b1; ratio_wdata = 8'd2;
        run_len(1'b0, a);
        run_len(1'b0, b);
        run_len(1'b0, c);
        chk("R3 high half in progress", a, 10);
        chk("R3 low half after fall", b, 3);
        chk("R3 high half new", c, 3);

        // R7: K held at 1 through reset; switches at 8th rise
        do_reset(2'd1);
        mis = 0;
        begin
            logic prev;
            int rises;
            prev = clk_hi;
            rises = 0;
            while (rises < 8) begin
                @(negedge clk_osc);
                if (!prev && clk_hi) rises++;
                prev = clk_hi;
                if (rises < 8 && clk_lo != clk_hi) mis++;
            end
        end
        chk("R7 lo follows hi before wrap", mis, 0);
        chk("R7 lo low at wrap rise", int'(clk_lo), 0);
        post_sel = 2'd3;
        period_of(1'b1, p, h);
        chk("R7 K change waits for wrap", p, 20);
        wait_rises(10);
        period_of(1'b1, p, h);
        chk("R7 new K after wrap", p, 80);

        // R8: independent inversion (K=0 so raw lo equals raw hi)
        do_reset(2'd0);
        wait_rises(2);
        inv_hi = 1'b1;
        repeat (3) @(negedge clk_osc);
        mis = 0; tog = 0;
        begin
            logic prev;
            prev = clk_hi;
            for (int j = 0; j < 40; j++) begin
                @(negedge clk_osc);
                if (clk_hi == clk_lo) mis++;
                if (clk_hi != prev) tog++;
                prev = clk_hi;
            end
        end
        chk("R8 hi inverted only", mis, 0);
        chk("R8 outputs toggling", int'(tog > 0), 1);
        inv_lo = 1'b1;
        repeat (3) @(negedge clk_osc);
        mis = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk_osc);
            if (clk_hi != clk_lo) mis++;
        end
        chk("R8 both inverted", mis, 0);
        wait_edge(1'b0, 1'b0);
        run_len(1'b0, a);
        chk("R8 inverted hi high time", a, 5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule